// File: doc/BRIEF.md
# Synchronising Register File with Thread Wakeup

This block is the register file of an in-order pipeline that runs many micro-threads. Every register doubles as a dataflow synchroniser. An entry is empty, full, or waiting. A waiting entry holds the reference of one suspended thread in place of data. A read of a full entry returns its data. A read of an empty entry does not stall the pipeline. The read is turned into a write that parks the reader's thread reference in the entry, and the block pulses a suspend indication carrying that reference.

A later data write to a waiting entry pulls the parked reference out and sends it to the scheduler on a reschedule pulse. The entry then holds the new data and is full. The allocator uses a separate clear port to return an entry to empty when it hands the register to a new micro-thread.

All results appear one clock after the request: read data, suspend, reschedule and the error flag.

Top module: `sync_regfile`

## Requirements
- R1: After reset every entry is empty. Each entry's 2-bit state is always 00 (empty), 01 (full) or 10 (waiting), never 11.
- R2: A read of a full entry raises `rd_vld` one cycle later, with the stored word on `rd_data`.
- R3: A read of an empty entry raises `susp_vld` one cycle later, with the reader's `rd_tref` on `susp_tref`. The entry becomes waiting and keeps the reference.
- R4: A write to a waiting entry raises `resch_vld` one cycle later, with the parked reference on `resch_tref`. The entry becomes full with the written word.
- R5: A write to a full or an empty entry stores the word and makes the entry full, with no reschedule pulse.
- R6: A read of a waiting entry raises `rd_err` one cycle later and leaves the entry and its parked reference unchanged.
- R7: A read and a write to the same entry in one cycle return the written word on `rd_data` and cause no suspension.
- R8: `clr_en` makes the addressed entry empty from the next cycle on.
- R9: A clear wins over any read or write to the same entry in the same cycle. The write is dropped, and the read raises `rd_err` instead of returning data or suspending.
- R10: `rd_vld`, `susp_vld` and `rd_err` are mutually exclusive. Every output pulse lasts one cycle per request, and all valid outputs stay low in a cycle after no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Entry to read |
| rd_tref | input | TREF_W | Thread reference of the reading instruction |
| wr_en | input | 1 | Data write request |
| wr_addr | input | ADDR_W | Entry to write |
| wr_data | input | DATA_W | Word to write |
| clr_en | input | 1 | Clear-to-empty request |
| clr_addr | input | ADDR_W | Entry to clear |
| rd_vld | output | 1 | Read returned data |
| rd_data | output | DATA_W | Returned word |
| rd_err | output | 1 | Read hit a waiting entry or a clear collision |
| susp_vld | output | 1 | Reading thread suspended |
| susp_tref | output | TREF_W | Reference of the suspended thread |
| resch_vld | output | 1 | Parked thread woken |
| resch_tref | output | TREF_W | Reference of the woken thread |

## Verification
Directed sequences first drive one entry through the full life cycle: empty read (suspend), second reader (error), waking write, then full read and overwrite. These show that each state gives its own response. Next come same-cycle collisions: read with write on one entry, and clear with read and write on one entry. These separate write-first forwarding from clear priority. A long random phase then confines addresses to a few entries, so that collisions and parked references pile up. A behavioural model is compared with the design on every clock, which exposes stale state or wrong reference routing.

// File: rtl/srf_pkg.sv
package srf_pkg;
   typedef enum logic [1:0] {
      ST_EMPTY = 2'b00,
      ST_FULL  = 2'b01,
      ST_WAIT  = 2'b10
   } srf_state_e;
endpackage

// File: rtl/srf_store.sv
module srf_store
   import srf_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_live,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic                           park_en,
   input  logic [ADDR_W-1:0]              park_addr,
   input  logic [DATA_W-1:0]              park_word,
   input  logic                           clr_en,
   input  logic [ADDR_W-1:0]              clr_addr,
   output logic [NUM_REGS-1:0][1:0]       st_q,
   output logic [NUM_REGS-1:0][DATA_W-1:0] data_q
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
      logic hit_clr, hit_wr, hit_park;
      assign hit_clr  = clr_en  && (clr_addr  == ADDR_W'(i));
      assign hit_wr   = wr_live && (wr_addr   == ADDR_W'(i));
      assign hit_park = park_en && (park_addr == ADDR_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[i]   <= ST_EMPTY;
            data_q[i] <= '0;
         end else if (hit_clr) begin
            st_q[i]   <= ST_EMPTY;
         end else if (hit_wr) begin
            st_q[i]   <= ST_FULL;
            data_q[i] <= wr_data;
         end else if (hit_park) begin
            st_q[i]   <= ST_WAIT;
            data_q[i] <= park_word;
         end
      end
   end
endmodule

// File: rtl/srf_decide.sv
module srf_decide
   import srf_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int TREF_W   = 8,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                            rd_en,
   input  logic [ADDR_W-1:0]               rd_addr,
   input  logic [TREF_W-1:0]               rd_tref,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic                            clr_en,
   input  logic [ADDR_W-1:0]               clr_addr,
   input  logic [NUM_REGS-1:0][1:0]        st_q,
   input  logic [NUM_REGS-1:0][DATA_W-1:0] data_q,
   output logic                            rd_ok,
   output logic [DATA_W-1:0]               rd_word,
   output logic                            rd_susp,
   output logic                            rd_bad,
   output logic                            park_en,
   output logic [DATA_W-1:0]               park_word,
   output logic                            wr_live,
   output logic                            wake,
   output logic [TREF_W-1:0]               wake_tref
);
   logic rd_clr_hit, rd_wr_hit;
   logic [1:0] rd_st;

   // Thread reference widened into a data-word slot
   if (TREF_W < DATA_W) begin : g_pad
      assign park_word = {{(DATA_W-TREF_W){1'b0}}, rd_tref};
   end else begin : g_nopad
      assign park_word = rd_tref;
   end

   assign wr_live    = wr_en && !(clr_en && clr_addr == wr_addr);
   assign rd_clr_hit = clr_en && (clr_addr == rd_addr);
   assign rd_wr_hit  = wr_en && (wr_addr == rd_addr);
   assign rd_st      = st_q[rd_addr];

   always_comb begin
      rd_ok   = 1'b0;
      rd_susp = 1'b0;
      rd_bad  = 1'b0;
      rd_word = data_q[rd_addr];
      if (rd_en) begin
         if (rd_clr_hit) begin
            rd_bad = 1'b1;
         end else if (rd_wr_hit) begin
            rd_ok   = 1'b1;
            rd_word = wr_data;
         end else begin
            unique case (rd_st)
               ST_FULL:  rd_ok   = 1'b1;
               ST_EMPTY: rd_susp = 1'b1;
               default:  rd_bad  = 1'b1;
            endcase
         end
      end
   end

   assign park_en   = rd_susp;
   assign wake      = wr_live && (st_q[wr_addr] == ST_WAIT);
   assign wake_tref = data_q[wr_addr][TREF_W-1:0];
endmodule

// File: rtl/srf_outreg.sv
module srf_outreg #(
   parameter int DATA_W = 32,
   parameter int TREF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_ok,
   input  logic [DATA_W-1:0] rd_word,
   input  logic              rd_susp,
   input  logic [TREF_W-1:0] rd_tref,
   input  logic              rd_bad,
   input  logic              wake,
   input  logic [TREF_W-1:0] wake_tref,
   output logic              rd_vld,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err,
   output logic              susp_vld,
   output logic [TREF_W-1:0] susp_tref,
   output logic              resch_vld,
   output logic [TREF_W-1:0] resch_tref
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_vld     <= 1'b0;
         rd_data    <= '0;
         rd_err     <= 1'b0;
         susp_vld   <= 1'b0;
         susp_tref  <= '0;
         resch_vld  <= 1'b0;
         resch_tref <= '0;
      end else begin
         rd_vld     <= rd_ok;
         rd_data    <= rd_word;
         rd_err     <= rd_bad;
         susp_vld   <= rd_susp;
         susp_tref  <= rd_tref;
         resch_vld  <= wake;
         resch_tref <= wake_tref;
      end
   end
endmodule

// File: rtl/sync_regfile.sv
module sync_regfile #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int TREF_W   = 8,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [TREF_W-1:0] rd_tref,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_addr,
   output logic              rd_vld,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err,
   output logic              susp_vld,
   output logic [TREF_W-1:0] susp_tref,
   output logic              resch_vld,
   output logic [TREF_W-1:0] resch_tref
);
   if (NUM_REGS < 2) begin : g_chk_regs
      $error("sync_regfile: NUM_REGS must be at least 2");
   end
   if (TREF_W < 1 || TREF_W > DATA_W) begin : g_chk_tref
      $error("sync_regfile: TREF_W must fit inside DATA_W");
   end

   logic [NUM_REGS-1:0][1:0]        st_q;
   logic [NUM_REGS-1:0][DATA_W-1:0] data_q;
   logic              rd_ok, rd_susp, rd_bad, park_en, wr_live, wake;
   logic [DATA_W-1:0] rd_word, park_word;
   logic [TREF_W-1:0] wake_tref;

   srf_decide #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TREF_W(TREF_W)) u_decide (
      .rd_en, .rd_addr, .rd_tref, .wr_en, .wr_addr, .wr_data, .clr_en, .clr_addr,
      .st_q, .data_q, .rd_ok, .rd_word, .rd_susp, .rd_bad, .park_en, .park_word,
      .wr_live, .wake, .wake_tref
   );

   srf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
      .clk, .rst_n, .wr_live, .wr_addr, .wr_data, .park_en,
      .park_addr(rd_addr), .park_word, .clr_en, .clr_addr, .st_q, .data_q
   );

   srf_outreg #(.DATA_W(DATA_W), .TREF_W(TREF_W)) u_out (
      .clk, .rst_n, .rd_ok, .rd_word, .rd_susp, .rd_tref, .rd_bad, .wake, .wake_tref,
      .rd_vld, .rd_data, .rd_err, .susp_vld, .susp_tref, .resch_vld, .resch_tref
   );
endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
   parameter int NUM_REGS = 16,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     rd_en,
   input logic [ADDR_W-1:0]        rd_addr,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic                     clr_en,
   input logic [ADDR_W-1:0]        clr_addr,
   input logic [NUM_REGS-1:0][1:0] st_q,
   input logic                     rd_vld,
   input logic                     rd_err,
   input logic                     susp_vld,
   input logic                     resch_vld
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_enc
      assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
         st_q[i] != 2'b11);
   end

   assert_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && st_q[rd_addr] == 2'b00 && !(wr_en && wr_addr == rd_addr)
       && !(clr_en && clr_addr == rd_addr))
      |=> (susp_vld && st_q[$past(rd_addr)] == 2'b10));

   assert_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && st_q[wr_addr] == 2'b10 && !(clr_en && clr_addr == wr_addr))
      |=> resch_vld);

   assert_wake_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      resch_vld |-> $past(wr_en));

   assert_no_wake_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && st_q[wr_addr] != 2'b10) |=> !resch_vld);

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> st_q[$past(clr_addr)] == 2'b00);

   assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_vld, susp_vld, rd_err}));

   assert_read_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld || susp_vld || rd_err) |-> $past(rd_en));
endmodule

bind sync_regfile srf_checker #(.NUM_REGS(NUM_REGS)) u_srf_checker (
   .clk, .rst_n, .rd_en, .rd_addr, .wr_en, .wr_addr, .clr_en, .clr_addr,
   .st_q, .rd_vld, .rd_err, .susp_vld, .resch_vld
);

// File: tb/test_sync_regfile.sv
module test_sync_regfile;
   localparam int PERIOD = 10;
   localparam int N  = 16;
   localparam int DW = 32;
   localparam int TW = 8;
   localparam int AW = $clog2(N);

   logic clk = 1'b0, rst_n = 1'b0;
   logic rd_en = 0, wr_en = 0, clr_en = 0;
   logic [AW-1:0] rd_addr = 0, wr_addr = 0, clr_addr = 0;
   logic [TW-1:0] rd_tref = 0;
   logic [DW-1:0] wr_data = 0;
   logic rd_vld, rd_err, susp_vld, resch_vld;
   logic [DW-1:0] rd_data;
   logic [TW-1:0] susp_tref, resch_tref;

   int total = 0, bad = 0;
   bit done = 0;

   // model: 0 empty, 1 full, 2 waiting
   int            m_st  [N];
   logic [DW-1:0] m_dat [N];
   bit e_rd, e_su, e_rs, e_er;
   logic [DW-1:0] e_dat;
   logic [TW-1:0] e_st, e_rt;

   always #(PERIOD/2) clk = ~clk;

   sync_regfile #(.NUM_REGS(N), .DATA_W(DW), .TREF_W(TW)) i_sync_regfile (
      .clk, .rst_n, .rd_en, .rd_addr, .rd_tref, .wr_en, .wr_addr, .wr_data,
      .clr_en, .clr_addr, .rd_vld, .rd_data, .rd_err, .susp_vld, .susp_tref,
      .resch_vld, .resch_tref
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(string tag);
      bit park = 0;
      bit wlive;
      @(posedge clk);
      e_rd = 0; e_su = 0; e_rs = 0; e_er = 0;
      wlive = wr_en && !(clr_en && clr_addr == wr_addr);
      if (rd_en) begin
         if (clr_en && clr_addr == rd_addr) e_er = 1;
         else if (wr_en && wr_addr == rd_addr) begin e_rd = 1; e_dat = wr_data; end
         else if (m_st[rd_addr] == 1) begin e_rd = 1; e_dat = m_dat[rd_addr]; end
         else if (m_st[rd_addr] == 0) begin e_su = 1; e_st = rd_tref; park = 1; end
         else e_er = 1;
      end
      if (wlive) begin
         if (m_st[wr_addr] == 2) begin e_rs = 1; e_rt = m_dat[wr_addr][TW-1:0]; end
         m_st[wr_addr] = 1;
         m_dat[wr_addr] = wr_data;
      end
      if (park) begin
         m_st[rd_addr] = 2;
         m_dat[rd_addr] = DW'(rd_tref);
      end
      if (clr_en) m_st[clr_addr] = 0;
      @(negedge clk);
      chk({tag, " R2 rd_vld"}, 64'(rd_vld), 64'(e_rd));
      chk({tag, " R3 susp_vld"}, 64'(susp_vld), 64'(e_su));
      chk({tag, " R4 resch_vld"}, 64'(resch_vld), 64'(e_rs));
      chk({tag, " R6 rd_err"}, 64'(rd_err), 64'(e_er));
      if (e_rd) chk({tag, " R2 rd_data"}, 64'(rd_data), 64'(e_dat));
      if (e_su) chk({tag, " R3 susp_tref"}, 64'(susp_tref), 64'(e_st));
      if (e_rs) chk({tag, " R4 resch_tref"}, 64'(resch_tref), 64'(e_rt));
   endtask

   task automatic drive(bit r, int ra, int tr, bit w, int wa, logic [DW-1:0] wd,
                        bit c, int ca);
      rd_en = r; rd_addr = AW'(ra); rd_tref = TW'(tr);
      wr_en = w; wr_addr = AW'(wa); wr_data = wd;
      clr_en = c; clr_addr = AW'(ca);
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_st[i] = 0; m_dat[i] = '0; end
      repeat (3) @(negedge clk);
      // R10: outputs quiet in reset
      chk("R10 reset outputs", 64'({rd_vld, susp_vld, resch_vld, rd_err}), 64'd0);
      rst_n = 1'b1;
      // R1 + R3: entry empty after reset, read suspends
      drive(1, 5, 'h11, 0, 0, 0, 0, 0); step("R1 R3 empty read");
      // R6: second reader on waiting entry
      drive(1, 5, 'h22, 0, 0, 0, 0, 0); step("R6 second reader");
      // R4: wake returns the first reference (entry unchanged by R6)
      drive(0, 0, 0, 1, 5, 32'hA5A5_0001, 0, 0); step("R4 wake");
      drive(1, 5, 0, 0, 0, 0, 0, 0); step("R2 full read");
      // R5: overwrite full entry, no wake
      drive(0, 0, 0, 1, 5, 32'h0000_BEEF, 0, 0); step("R5 overwrite");
      drive(1, 5, 0, 0, 0, 0, 0, 0); step("R5 read back");
      // R5: write to empty entry
      drive(0, 0, 0, 1, 9, 32'h1234_5678, 0, 0); step("R5 write empty");
      // R7: read and write same entry same cycle
      drive(1, 3, 'h33, 1, 3, 32'hCAFE_0003, 0, 0); step("R7 collision");
      // R8: clear then read suspends
      drive(0, 0, 0, 0, 0, 0, 1, 3); step("R8 clear");
      drive(1, 3, 'h44, 0, 0, 0, 0, 0); step("R8 read after clear");
      // R9: clear beats read and write on one entry
      drive(1, 4, 'h55, 1, 4, 32'hDEAD_0004, 1, 4); step("R9 clear wins");
      drive(1, 4, 'h66, 0, 0, 0, 0, 0); step("R9 write dropped");
      // R10: idle cycle
      drive(0, 0, 0, 0, 0, 0, 0, 0); step("R10 idle");
      step("R10 idle2");
      // random mix on a few entries
      for (int k = 0; k < 3000; k++) begin
         drive($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 255),
               $urandom_range(0, 1), $urandom_range(0, 3), $urandom(),
               ($urandom_range(0, 7) == 0), $urandom_range(0, 3));
         step("rand");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule